// File: doc/BRIEF.md
# Fixed-Point ALU with Condition Codes

This block is the integer arithmetic unit for a two's-complement machine word. The word is `W` bits wide and 32 by default. Each cycle it can accept one operation from a 3-bit op code. There are two kinds of operation. Additive operations work on two register operands: signed add and subtract, and logical (unsigned) add and subtract. Load-type operations work on the second operand alone: complement, force non-positive and force non-negative. The result word and a 2-bit condition code are registered. They appear one cycle after the operation is accepted, together with a one-cycle valid strobe.

Signed and logical additive operations produce the same result bits. They differ only in how the condition code is formed. A signed overflow always shows in the condition code. It also raises a fixed-point-overflow interrupt request, but only when the program's overflow mask bit is one. The most negative value has no positive counterpart in the same width. Complementing it, or taking its magnitude, returns the value unchanged and reports overflow.

Top module: `fxalu`

## Requirements
- R1: Signed add (op 0) and signed subtract (op 1) return the true result reduced modulo 2^W. Overflow is reported exactly when the true result lies outside [-2^(W-1), 2^(W-1)-1], and reporting it does not change the result bits.
- R2: For signed and load operations the condition code is 0 for a zero result, 1 for a negative result, 2 for a positive result and 3 for overflow.
- R3: Logical add (op 2) and logical subtract (op 3) return the same result bits as the signed versions. The condition code bit 1 is the carry out of the top bit, and bit 0 is one when the result is nonzero. For subtract, a carry out means the unsigned minuend was not below the subtrahend.
- R4: Logical operations never report overflow and never raise the interrupt request.
- R5: Load complement (op 4) returns the negated second operand. For the most negative value (top bit one, all other bits zero) it returns that same value with condition code 3 and overflow.
- R6: Load negative (op 5) returns a non-positive result. A positive operand is negated, while negative operands and zero pass through unchanged. It never overflows.
- R7: Load positive (op 6) returns the magnitude of the second operand. The most negative value passes through unchanged with condition code 3 and overflow.
- R8: The interrupt request is high in a result cycle exactly when that operation overflowed under a signed or load op code and the overflow mask input was one when the operation was presented.
- R9: Outputs are registered. A result, its condition code and its strobe appear on the first clock edge after the operation is presented, and the strobe is low in every other cycle.
- R10: Op code 7, or a cycle with the issue input low, produces no strobe and no interrupt request, and leaves the result and condition code unchanged.
- R11: A synchronous active-low reset clears the result, condition code, strobe and interrupt request to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue | input | 1 | An operation is presented this cycle |
| opcode | input | 3 | Operation select (0..6 defined, 7 unused) |
| opnd_a | input | W | First operand (additive operations only) |
| opnd_b | input | W | Second operand |
| ovf_mask | input | 1 | Program overflow mask bit |
| res_valid | output | 1 | Result strobe |
| res | output | W | Result word |
| cc | output | 2 | Condition code |
| ovf_irq | output | 1 | Fixed-point-overflow interrupt request |

## Verification
On every cycle the assertions check the following. The interrupt request only ever appears with condition code 3 and a masked-in operation. Logical operations never raise the request. The unused op code leaves the condition code untouched. Load negative never yields a positive result. Complementing or taking the magnitude of the most negative value returns it unchanged with condition code 3. Only the bench's sweep can show that each wrapped result and each carry and borrow bit is arithmetically right for every operand pair, including subtracting the most negative value from -1 without overflow.

// File: rtl/fxalu_pkg.sv
// Package: op codes and condition-code constants shared by the ALU modules.
// Assumes a 3-bit op code; code 7 is reserved and treated as no operation.
package fxalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_ADDL  = 3'd2,
        OP_SUBL  = 3'd3,
        OP_LCOMP = 3'd4,
        OP_LNEG  = 3'd5,
        OP_LPOS  = 3'd6,
        OP_RSVD  = 3'd7
    } fx_op_e;

    localparam logic [1:0] CC_ZERO = 2'd0;
    localparam logic [1:0] CC_NEG  = 2'd1;
    localparam logic [1:0] CC_POS  = 2'd2;
    localparam logic [1:0] CC_OVF  = 2'd3;

    // True for the op codes that use the unsigned condition code.
    function automatic logic is_logical_op(input fx_op_e op);
        return (op == OP_ADDL) || (op == OP_SUBL);
    endfunction

    // True for the single-operand load op codes.
    function automatic logic is_load_op(input fx_op_e op);
        return (op == OP_LCOMP) || (op == OP_LNEG) || (op == OP_LPOS);
    endfunction

endpackage

// File: rtl/fxalu_opsel.sv
// Operand selector: turns every op code into one adder pass a + b' + cin.
// Subtraction and negation invert b and inject a carry of one. Loads force a to zero.
// Assumes W >= 2. Pass-through loads present 0 + b with no carry, which cannot overflow.
module fxalu_opsel
    import fxalu_pkg::*;
#(
    parameter int W = 32
) (
    input  fx_op_e          op,
    input  logic [W-1:0]    a_in,
    input  logic [W-1:0]    b_in,
    output logic [W-1:0]    add_a,
    output logic [W-1:0]    add_b,
    output logic            add_cin,
    output logic            logical,
    output logic            legal
);

    logic b_neg;
    logic b_nonzero;
    logic negate;
    logic invert;

    // Classify operand b and decide whether a load must negate it.
    always_comb begin
        b_neg     = b_in[W-1];
        b_nonzero = |b_in;
        negate    = (op == OP_LCOMP)
                  | ((op == OP_LNEG) & ~b_neg & b_nonzero)
                  | ((op == OP_LPOS) & b_neg);
        invert    = (op == OP_SUB) | (op == OP_SUBL) | negate;
    end

    // Drive the adder inputs and the op class flags.
    always_comb begin
        add_a   = is_load_op(op) ? '0 : a_in;
        add_b   = invert ? ~b_in : b_in;
        add_cin = invert;
        logical = is_logical_op(op);
        legal   = (op != OP_RSVD);
    end

endmodule

// File: rtl/fxalu_adder.sv
// Split adder: the low W-1 bits and the sign bit are added separately.
// This exposes both the carry into the sign position and the carry out of it.
// Assumes W >= 2.
module fxalu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_sign,
    output logic         c_out
);

    localparam int LW = W - 1;

    logic [LW:0] low_sum;
    logic [1:0]  top_sum;

    // Add the numeric bits; the extra top bit is the carry into the sign.
    always_comb begin
        low_sum = {1'b0, x[LW-1:0]} + {1'b0, y[LW-1:0]} + {{LW{1'b0}}, cin};
        c_sign  = low_sum[LW];
    end

    // Add the sign bits plus the incoming carry.
    always_comb begin
        top_sum = {1'b0, x[W-1]} + {1'b0, y[W-1]} + {1'b0, c_sign};
        c_out   = top_sum[1];
        sum     = {top_sum[0], low_sum[LW-1:0]};
    end

endmodule

// File: rtl/fxalu_ccgen.sv
// Condition-code generator. Signed class: overflow when the two sign carries
// disagree, otherwise zero / negative / positive. Logical class: {carry, nonzero}.
// Assumes the adder already applied any inversion for subtraction.
module fxalu_ccgen
    import fxalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] sum,
    input  logic         c_sign,
    input  logic         c_out,
    input  logic         logical,
    output logic [1:0]   cc,
    output logic         ovf
);

    logic nonzero;

    // Classify the sum and select the code for the op class.
    always_comb begin
        nonzero = |sum;
        if (logical) begin
            ovf = 1'b0;
            cc  = {c_out, nonzero};
        end else begin
            ovf = c_out ^ c_sign;
            if (ovf)            cc = CC_OVF;
            else if (!nonzero)  cc = CC_ZERO;
            else if (sum[W-1])  cc = CC_NEG;
            else                cc = CC_POS;
        end
    end

endmodule

// File: rtl/fxalu.sv
// Fixed-point ALU top: operand selection, one adder, code generation, output register.
// Assumes one operation per cycle, with no back-pressure. Results appear one edge later.
// The synchronous active-low reset clears all registered outputs.
module fxalu
    import fxalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [2:0]   opcode,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         ovf_mask,
    output logic         res_valid,
    output logic [W-1:0] res,
    output logic [1:0]   cc,
    output logic         ovf_irq
);

    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    fx_op_e       op;
    logic [W-1:0] add_a, add_b, sum;
    logic         add_cin, logical, legal;
    logic         c_sign, c_out;
    logic [1:0]   cc_d;
    logic         ovf_d;
    logic         accept;

    assign op     = fx_op_e'(opcode);
    assign accept = issue & legal;

    fxalu_opsel #(.W(W)) u_opsel (
        .op      (op),
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .add_a   (add_a),
        .add_b   (add_b),
        .add_cin (add_cin),
        .logical (logical),
        .legal   (legal)
    );

    fxalu_adder #(.W(W)) u_adder (
        .x      (add_a),
        .y      (add_b),
        .cin    (add_cin),
        .sum    (sum),
        .c_sign (c_sign),
        .c_out  (c_out)
    );

    fxalu_ccgen #(.W(W)) u_ccgen (
        .sum     (sum),
        .c_sign  (c_sign),
        .c_out   (c_out),
        .logical (logical),
        .cc      (cc_d),
        .ovf     (ovf_d)
    );

    // Register the result, code, strobe and masked interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res       <= '0;
            cc        <= CC_ZERO;
            ovf_irq   <= 1'b0;
        end else begin
            res_valid <= accept;
            ovf_irq   <= accept & ovf_d & ovf_mask;
            if (accept) begin
                res <= sum;
                cc  <= cc_d;
            end
        end
    end

    AST_IRQ_WITH_CC3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (res_valid && cc == CC_OVF)); // R8
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> $past(ovf_mask && issue)); // R8
    AST_LOGICAL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op == OP_ADDL || op == OP_SUBL)) |=> !ovf_irq); // R4
    AST_STROBE_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(issue && opcode != 3'd7)); // R9
    AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_RSVD) |=> (!res_valid && $stable(cc) && $stable(res))); // R10
    AST_LNEG_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_LNEG) |=> (res[W-1] || res == '0) && cc != CC_POS); // R6
    AST_LCOMP_MAXNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_LCOMP && opnd_b == MAX_NEG) |=> (res == MAX_NEG && cc == CC_OVF)); // R5
    AST_LPOS_MAXNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_LPOS && opnd_b == MAX_NEG) |=> (res == MAX_NEG && cc == CC_OVF)); // R7

endmodule

// File: tb/fxalu_tb.sv
// Exhaustive sweep of a 4-bit configuration: every op code, operand pair and mask value.
module fxalu_tb;

    localparam int WB   = 4;
    localparam int MOD  = 1 << WB;
    localparam int HALF = 1 << (WB - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue = 1'b0;
    logic [2:0]    opcode = 3'd0;
    logic [WB-1:0] opnd_a = '0;
    logic [WB-1:0] opnd_b = '0;
    logic          ovf_mask = 1'b0;
    logic          res_valid;
    logic [WB-1:0] res;
    logic [1:0]    cc;
    logic          ovf_irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [WB-1:0] hold_res = '0;
    logic [1:0]    hold_cc  = 2'd0;

    always #5 clk = ~clk;

    fxalu #(.W(WB)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .ovf_mask(ovf_mask),
        .res_valid(res_valid), .res(res), .cc(cc), .ovf_irq(ovf_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (op %0d a %0d b %0d m %0d)",
                     tag, act, exp, opcode, opnd_a, opnd_b, ovf_mask);
        end
    endtask

    // Present one operation, wait one edge, compare with the arithmetic model.
    task automatic do_op(input logic iss, input int op, input int au, input int bu, input logic m);
        int as, bs, t, s;
        logic ovf, vld;
        logic [WB-1:0] r;
        logic [1:0] c;
        string rtag, ctag;
        @(negedge clk);
        issue = iss; opcode = op[2:0]; opnd_a = au[WB-1:0]; opnd_b = bu[WB-1:0]; ovf_mask = m;
        as = (au >= HALF) ? au - MOD : au;
        bs = (bu >= HALF) ? bu - MOD : bu;
        ovf = 1'b0; t = 0; s = 0;
        vld = iss && (op != 7);
        case (op)
            0: begin t = as + bs; rtag = "R1"; ctag = "R2"; end
            1: begin t = as - bs; rtag = "R1"; ctag = "R2"; end
            4: begin t = -bs; rtag = "R5"; ctag = "R5"; end
            5: begin t = (bs > 0) ? -bs : bs; rtag = "R6"; ctag = "R6"; end
            6: begin t = (bs < 0) ? -bs : bs; rtag = "R7"; ctag = "R7"; end
            default: begin rtag = "R3"; ctag = "R3"; end
        endcase
        if (op == 2 || op == 3) begin
            s = (op == 2) ? au + bu : au - bu + MOD;
            r = s[WB-1:0];
            c = {(s >= MOD), (r != 0)};
        end else begin
            r   = t[WB-1:0];
            ovf = (t > HALF - 1) || (t < -HALF);
            c   = ovf ? 2'd3 : (r == 0) ? 2'd0 : r[WB-1] ? 2'd1 : 2'd2;
        end
        if (!vld) begin
            r = hold_res; c = hold_cc; ovf = 1'b0;
            rtag = "R10"; ctag = "R10";
        end
        @(posedge clk);
        #2;
        check(rtag, int'(res), int'(r));
        check(ctag, int'(cc), int'(c));
        check(vld ? "R9" : "R10", int'(res_valid), int'(vld));
        check((op == 2 || op == 3) ? "R4" : "R8", int'(ovf_irq), int'(ovf & m & vld));
        hold_res = r; hold_cc = c;
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R11", int'(res_valid), 0);
        check("R11", int'(res), 0);
        check("R11", int'(cc), 0);
        check("R11", int'(ovf_irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // Full sweep, including the unused op code and -1 minus the most negative value.
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < MOD; a++)
                for (int b = 0; b < MOD; b++)
                    for (int m = 0; m < 2; m++)
                        do_op(1'b1, op, a, b, m[0]);
        // Issue low: nothing must change (R10).
        do_op(1'b1, 0, 3, 2, 1'b0);
        for (int k = 0; k < 8; k++) do_op(1'b0, k, k, 15 - k, 1'b1);
        // Leave an overflow pending in the registers, then reset (R11).
        do_op(1'b1, 4, 0, HALF, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R11", int'(res_valid), 0);
        check("R11", int'(res), 0);
        check("R11", int'(cc), 0);
        check("R11", int'(ovf_irq), 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule